// File: doc/BRIEF.md
# Chip Reset Sequencer

This block runs the chip-level reset flow. Any of three sources starts it: the power-on reset, a low pulse on the shared active-low reset pin, or a request from inside the chip. In every case the flow is the same. The internal system reset is asserted, and the reset pin is pulled low through an open-drain driver. The block enables the clocks that are needed, takes the flash controller out of reset and captures the nonvolatile option byte. It keeps pulling the pin low until the flash controller reports that it is ready.

After that the block lets go of the pin and watches the level it reads back. Any board device that still holds the pin low keeps the whole chip in reset. Once the pin reads high, the core clock is turned on, and one cycle later the system reset is released. Flash is therefore ready before the core fetches its first words from the vector table at address 0.

The pad itself sits outside the block. It exposes `pinDrvLow`, which enables the low drive, and takes `pinIn`, the level read back from the pad. A sticky cause register records which sources have reset the chip since the last power-on.

Top module: `rst_sequencer`

## Requirements
- R1: While `porRstN` is low, and in the first cycle after an accepted request, these outputs hold: `sysRstN`=0, `pinDrvLow`=1, `flashRstN`=0, and every clock enable (`sysClkEn`, `flashClkEn`, `busClkEn`, `coreClkEn`) is 0.
- R2: One cycle after that first cycle, `sysClkEn` and `flashClkEn` turn on. Each `busClkEn` bit turns on when the matching bit of parameter `BUS_ON_MASK` (default 4'b0101) is 1, and stays 0 otherwise. These enables stay on until the next reset.
- R3: `flashRstN` rises one cycle after the clocks turn on. At that point `sysRstN` is still low and `pinDrvLow` is still high.
- R4: One cycle after the flash release, `optRdEn` goes high. It stays high until `optRdValid` is seen, and the `optRdData` of that cycle is stored in `optByte`. `optByte` keeps its value through later flows, and power-on sets it to 8'hFF.
- R5: `pinDrvLow` drops only after `flashInitDone` has been sampled high. While the flash is still initialising, the pin stays driven.
- R6: Once the drive stops, the system reset stays asserted for as long as `pinIn` is low. `coreClkEn` rises on the third rising edge after `pinIn` goes high, and `sysRstN` rises on the fourth edge.
- R7: `coreClkEn` is high for one cycle before `sysRstN` rises. In the run state both stay high.
- R8: While the chip is running, `pinIn` low for `FILT_LEN` (default 4) or more consecutive synchronized samples restarts the full flow. A shorter low pulse has no effect.
- R9: While the chip is running, `intRstReq` high restarts the full flow. While a flow is already in progress, `intRstReq` is ignored.
- R10: `rstCause` is a sticky register: bit 0 marks power-on, bit 1 the pin, bit 2 the internal request. An accepted source sets its bit. Power-on alone clears the register, to 3'b001.
- R11: `sysRstN` is never high unless `flashRstN` is high and `flashInitDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| intRstReq | input | 1 | Internal reset request |
| pinIn | input | 1 | Level read back from the reset pin pad |
| pinDrvLow | output | 1 | Open-drain enable; 1 pulls the reset pin low |
| sysClkEn | output | 1 | System clock enable |
| flashClkEn | output | 1 | Flash clock enable |
| busClkEn | output | NUM_BUS | Bus clock enables |
| coreClkEn | output | 1 | Core clock enable |
| flashRstN | output | 1 | Flash controller reset, active low |
| flashInitDone | input | 1 | Flash controller finished initialising |
| optRdEn | output | 1 | Option byte read request |
| optRdValid | input | 1 | Option byte data valid |
| optRdData | input | OPT_W | Option byte data |
| optByte | output | OPT_W | Latched option byte |
| rstCause | output | 3 | Sticky reset cause bits |
| sysRstN | output | 1 | System reset, active low |

## Verification
The bench aims at these corner cases, each paired with the failure it would expose:
- **Pulse exactly `FILT_LEN` long, and one sample shorter.** An off-by-one filter would either ignore a valid pin reset or reset on a glitch.
- **Pin held low by an outside device for several cycles after the drive stops.** A design that releases on flash-done alone would let the core start while the board still holds reset. Counting the held cycles exposes any early or late release.
- **Flash that is slower than the option read, and flash that is ready at once.** A pin released on the option read rather than on flash-done would show up.
- **An internal request in the middle of a flow.** A design that restarts on it would reset twice or set a wrong cause bit.
- **A second power-on.** A cause register that never clears would keep its stale bits.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_RUN      = 3'd0,
    ST_ASSERT        = 3'd1,
    ST_CLK_EN        = 3'd2,
    ST_FLASH_INIT    = 3'd3,
    ST_OPT_LOAD      = 3'd4,
    ST_PIN_RELEASE   = 3'd5,
    ST_WAIT_PIN_HIGH = 3'd6,
    ST_RELEASE       = 3'd7
  } seqState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic optLatch;
    logic causePin;
    logic causeInt;
  } dpStrobe_t;

  // Status from the datapath back to the control FSM.
  typedef struct packed {
    logic pinSync;
    logic pinReq;
  } dpStatus_t;

  localparam int CAUSE_W   = 3;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_INT = 2;

endpackage

// File: rtl/rstseq_dp.sv
`timescale 1ns/1ps
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int OPT_W       = 8
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                pinIn,
  input  dpStrobe_t           strobe,
  input  logic [OPT_W-1:0]    optRdData,
  output dpStatus_t           status,
  output logic [OPT_W-1:0]    optByte,
  output logic [CAUSE_W-1:0]  rstCause
);

  localparam int              CNT_W    = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] FILT_MAX = CNT_W'(FILT_LEN);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [CNT_W-1:0]       lowCnt;

  // Pin synchronizer chain.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) syncQ <= '0;
    else          syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  // Counts consecutive low samples, saturating at FILT_LEN.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                lowCnt <= '0;
    else if (syncOut)            lowCnt <= '0;
    else if (lowCnt != FILT_MAX) lowCnt <= lowCnt + 1'b1;
  end

  assign status.pinSync = syncOut;
  assign status.pinReq  = (lowCnt == FILT_MAX);

  // Option byte holding register; power-on value is the erased state.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)            optByte <= '1;
    else if (strobe.optLatch) optByte <= optRdData;
  end

  // Sticky cause bits; only power-on clears them.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      rstCause            <= '0;
      rstCause[CAUSE_POR] <= 1'b1;
    end else begin
      if (strobe.causePin) rstCause[CAUSE_PIN] <= 1'b1;
      if (strobe.causeInt) rstCause[CAUSE_INT] <= 1'b1;
    end
  end

  a_r4_opt_capture: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.optLatch |=> (optByte == $past(optRdData)));

  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!porRstN)
    (($past(rstCause) & ~rstCause) == '0));

  a_r8_pin_was_low: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.causePin |-> $past(!syncOut));

endmodule

// File: rtl/rstseq_ctrl.sv
`timescale 1ns/1ps
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int                 NUM_BUS     = 4,
  parameter logic [NUM_BUS-1:0] BUS_ON_MASK = 4'b0101
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               intRstReq,
  input  dpStatus_t          status,
  input  logic               flashInitDone,
  input  logic               optRdValid,
  output dpStrobe_t          strobe,
  output logic               pinDrvLow,
  output logic               sysClkEn,
  output logic               flashClkEn,
  output logic [NUM_BUS-1:0] busClkEn,
  output logic               coreClkEn,
  output logic               flashRstN,
  output logic               optRdEn,
  output logic               sysRstN
);

  seqState_t stateQ, stateD;
  logic      clkOn;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) stateQ <= ST_ASSERT;
    else          stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE_RUN:      if (status.pinReq || intRstReq) stateD = ST_ASSERT;
      ST_ASSERT:        stateD = ST_CLK_EN;
      ST_CLK_EN:        stateD = ST_FLASH_INIT;
      ST_FLASH_INIT:    stateD = ST_OPT_LOAD;
      ST_OPT_LOAD:      if (optRdValid) stateD = ST_PIN_RELEASE;
      ST_PIN_RELEASE:   if (flashInitDone) stateD = ST_WAIT_PIN_HIGH;
      ST_WAIT_PIN_HIGH: if (status.pinSync) stateD = ST_RELEASE;
      ST_RELEASE:       stateD = ST_IDLE_RUN;
      default:          stateD = ST_ASSERT;
    endcase
  end

  // Moore decode of the outputs from the state register.
  assign clkOn      = (stateQ != ST_ASSERT);
  assign sysClkEn   = clkOn;
  assign flashClkEn = clkOn;
  assign flashRstN  = !(stateQ inside {ST_ASSERT, ST_CLK_EN});
  assign pinDrvLow  = stateQ inside {ST_ASSERT, ST_CLK_EN, ST_FLASH_INIT,
                                     ST_OPT_LOAD, ST_PIN_RELEASE};
  assign coreClkEn  = stateQ inside {ST_RELEASE, ST_IDLE_RUN};
  assign sysRstN    = (stateQ == ST_IDLE_RUN);
  assign optRdEn    = (stateQ == ST_OPT_LOAD);

  // Bus clocks: only those whose gate defaults to on are enabled here.
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    if (BUS_ON_MASK[b]) begin : g_on
      assign busClkEn[b] = clkOn;
    end else begin : g_off
      assign busClkEn[b] = 1'b0;
    end
  end

  assign strobe.optLatch = (stateQ == ST_OPT_LOAD) && optRdValid;
  assign strobe.causePin = (stateQ == ST_IDLE_RUN) && status.pinReq;
  assign strobe.causeInt = (stateQ == ST_IDLE_RUN) && intRstReq;

  a_r1_entry_state: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(sysRstN) |-> (pinDrvLow && !sysClkEn && !flashRstN && !coreClkEn));

  a_r3_flash_after_clocks: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(flashRstN) |-> $past(sysClkEn && flashClkEn));

  a_r5_pin_after_flash: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(pinDrvLow) |-> $past(flashInitDone));

  a_r6_core_after_pin_high: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(coreClkEn) |-> $past(status.pinSync));

  a_r7_core_before_sys: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(sysRstN) |-> $past(coreClkEn));

  a_r9_restart_from_run: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(pinDrvLow) |-> $past(sysRstN));

endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
module rst_sequencer
  import rstseq_pkg::*;
#(
  parameter int                 NUM_BUS     = 4,
  parameter logic [NUM_BUS-1:0] BUS_ON_MASK = 4'b0101,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 FILT_LEN    = 4,
  parameter int                 OPT_W       = 8
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               intRstReq,
  input  logic               pinIn,
  output logic               pinDrvLow,
  output logic               sysClkEn,
  output logic               flashClkEn,
  output logic [NUM_BUS-1:0] busClkEn,
  output logic               coreClkEn,
  output logic               flashRstN,
  input  logic               flashInitDone,
  output logic               optRdEn,
  input  logic               optRdValid,
  input  logic [OPT_W-1:0]   optRdData,
  output logic [OPT_W-1:0]   optByte,
  output logic [CAUSE_W-1:0] rstCause,
  output logic               sysRstN
);

  dpStrobe_t strobe;
  dpStatus_t status;

  rstseq_ctrl #(
    .NUM_BUS     (NUM_BUS),
    .BUS_ON_MASK (BUS_ON_MASK)
  ) uCtrl (
    .clk           (clk),
    .porRstN       (porRstN),
    .intRstReq     (intRstReq),
    .status        (status),
    .flashInitDone (flashInitDone),
    .optRdValid    (optRdValid),
    .strobe        (strobe),
    .pinDrvLow     (pinDrvLow),
    .sysClkEn      (sysClkEn),
    .flashClkEn    (flashClkEn),
    .busClkEn      (busClkEn),
    .coreClkEn     (coreClkEn),
    .flashRstN     (flashRstN),
    .optRdEn       (optRdEn),
    .sysRstN       (sysRstN)
  );

  rstseq_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN),
    .OPT_W       (OPT_W)
  ) uDp (
    .clk       (clk),
    .porRstN   (porRstN),
    .pinIn     (pinIn),
    .strobe    (strobe),
    .optRdData (optRdData),
    .status    (status),
    .optByte   (optByte),
    .rstCause  (rstCause)
  );

endmodule

// File: tb/sim_rst_sequencer.sv
`timescale 1ns/1ps
module sim_rst_sequencer;

  localparam logic [3:0] MASK = 4'b0101;

  typedef struct packed {
    logic [1:0] kind;      // 0: pin pulse, 1: internal request
    logic [7:0] len;
    logic [7:0] dly;
    logic [7:0] hold;
    logic [7:0] data;
    logic [7:0] expOpt;
    logic [2:0] expCause;
    logic       expRst;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{2'd0, 8'd10, 8'd5,  8'd0,  8'hA5, 8'hA5, 3'b011, 1'b1},
    '{2'd1, 8'd1,  8'd3,  8'd3,  8'h3C, 8'h3C, 3'b111, 1'b1},
    '{2'd0, 8'd3,  8'd4,  8'd0,  8'h00, 8'h3C, 3'b111, 1'b0},
    '{2'd0, 8'd4,  8'd12, 8'd7,  8'h81, 8'h81, 3'b111, 1'b1},
    '{2'd0, 8'd1,  8'd4,  8'd0,  8'h00, 8'h81, 3'b111, 1'b0},
    '{2'd1, 8'd1,  8'd0,  8'd0,  8'h7E, 8'h7E, 3'b111, 1'b1},
    '{2'd0, 8'd10, 8'd1,  8'd15, 8'hC3, 8'hC3, 3'b111, 1'b1}
  };

  logic clk = 1'b0, porRstN = 1'b0, intRstReq = 1'b0;
  logic pulseLow = 1'b0, holdLow = 1'b0, optRdValid = 1'b0;
  logic [7:0] optRdData = 8'h5A;
  logic pinIn, pinDrvLow, sysClkEn, flashClkEn, coreClkEn, flashRstN;
  logic optRdEn, sysRstN, flashInitDone;
  logic [3:0] busClkEn;
  logic [7:0] optByte;
  logic [2:0] rstCause;

  int flashDly = 6, flashCnt = 0;
  int nChk = 0, nFail = 0;
  int relLowCnt = 0, holdCnt = 0, holdLen = 0;
  int vR1 = 0, vR2 = 0, vR3 = 0, vR5 = 0, vR7 = 0, vR11 = 0;
  bit sawReset = 0;
  logic prevSys = 1'b0, prevCore = 1'b0;

  assign pinIn = ~(pinDrvLow | pulseLow | holdLow);
  assign flashInitDone = flashRstN && (flashCnt >= flashDly);

  rst_sequencer u0 (
    .clk(clk), .porRstN(porRstN), .intRstReq(intRstReq), .pinIn(pinIn),
    .pinDrvLow(pinDrvLow), .sysClkEn(sysClkEn), .flashClkEn(flashClkEn),
    .busClkEn(busClkEn), .coreClkEn(coreClkEn), .flashRstN(flashRstN),
    .flashInitDone(flashInitDone), .optRdEn(optRdEn), .optRdValid(optRdValid),
    .optRdData(optRdData), .optByte(optByte), .rstCause(rstCause), .sysRstN(sysRstN)
  );

  always #10 clk = ~clk;

  // Flash / option models, pin holder and protocol monitor.
  always @(negedge clk) begin
    if (!flashRstN) flashCnt = 0;
    else if (flashCnt < 1000) flashCnt++;
    optRdValid = optRdEn;
    if (porRstN) begin
      if (!sysRstN) sawReset = 1;
      if (!sysRstN && !pinDrvLow) relLowCnt++;
      if (prevSys && !sysRstN &&
          !(pinDrvLow && !sysClkEn && !flashRstN && !coreClkEn && busClkEn == 4'b0)) vR1++;
      if (busClkEn != (sysClkEn ? MASK : 4'b0) || sysClkEn != flashClkEn) vR2++;
      if (flashRstN && !(sysClkEn && flashClkEn)) vR3++;
      if (!sysRstN && flashRstN && !flashInitDone && !pinDrvLow) vR5++;
      if (sysRstN && !prevSys && !prevCore) vR7++;
      if (sysRstN && !coreClkEn) vR7++;
      if (sysRstN && !(flashRstN && flashInitDone)) vR11++;
    end
    if (holdLow && !pinDrvLow && !sysRstN) begin
      if (holdCnt >= holdLen) holdLow = 0;
      else holdCnt++;
    end
    prevSys = sysRstN;
    prevCore = coreClkEn;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    relLowCnt = 0; sawReset = 0;
    vR1 = 0; vR2 = 0; vR3 = 0; vR5 = 0; vR7 = 0; vR11 = 0;
  endtask

  task automatic waitRun(input string req);
    int n = 0;
    while (!sysRstN && n < 3000) begin @(negedge clk); n++; end
    check(sysRstN == 1'b1, req, sysRstN, 1);
    @(negedge clk);
  endtask

  task automatic flowChecks(input int hold, input logic [7:0] expOpt, input logic [2:0] expCause);
    check(relLowCnt == hold + 4, "R6 held-release cycles", relLowCnt, hold + 4);
    check(optByte == expOpt, "R4 option byte", optByte, expOpt);
    check(rstCause == expCause, "R10 cause", rstCause, expCause);
    check(vR1 == 0, "R1 entry state", vR1, 0);
    check(vR2 == 0 && busClkEn == MASK, "R2 clock enables", busClkEn, MASK);
    check(vR3 == 0, "R3 flash release order", vR3, 0);
    check(vR5 == 0, "R5 pin held until flash done", vR5, 0);
    check(vR7 == 0 && coreClkEn, "R7 core clock before release", vR7, 0);
    check(vR11 == 0, "R11 flash ready at release", vR11, 0);
  endtask

  task automatic powerOn();
    porRstN = 1'b0;
    holdLow = 1'b0; pulseLow = 1'b0;
    repeat (3) @(negedge clk);
    check(!sysRstN && pinDrvLow && !flashRstN, "R1 reset outputs",
          {sysRstN, pinDrvLow, flashRstN}, 3'b010);
    check(!sysClkEn && !flashClkEn && busClkEn == 4'b0 && !coreClkEn, "R1 clocks off",
          {sysClkEn, flashClkEn, busClkEn, coreClkEn}, 0);
    check(optByte == 8'hFF, "R4 power-on option", optByte, 8'hFF);
    check(rstCause == 3'b001, "R10 power-on cause", rstCause, 3'b001);
    clearMon();
    porRstN = 1'b1;
    @(negedge clk);
    check(sysClkEn && busClkEn == MASK && !flashRstN, "R2 clocks one cycle in",
          {sysClkEn, busClkEn, flashRstN}, {1'b1, MASK, 1'b0});
    @(negedge clk);
    check(flashRstN && pinDrvLow && !sysRstN, "R3 flash released under reset",
          {flashRstN, pinDrvLow, sysRstN}, 3'b110);
    @(negedge clk);
    check(optRdEn == 1'b1, "R4 option read request", optRdEn, 1);
    waitRun("R6 power-on release");
  endtask

  task automatic runVec(input vec_t v);
    int n;
    optRdData = v.data;
    flashDly = int'(v.dly);
    holdLen = int'(v.hold);
    clearMon();
    @(negedge clk);
    if (v.kind == 2'd0) begin
      pulseLow = 1'b1;
      repeat (int'(v.len)) @(negedge clk);
      pulseLow = 1'b0;
    end else begin
      intRstReq = 1'b1;
      @(negedge clk);
      intRstReq = 1'b0;
    end
    if (v.expRst) begin
      n = 0;
      while (sysRstN && n < 50) begin @(negedge clk); n++; end
      check(!sysRstN, (v.kind == 2'd0) ? "R8 pin restart" : "R9 request restart", sysRstN, 0);
      holdCnt = 0;
      holdLow = (v.hold != 0);
      waitRun("R6 release after flow");
      flowChecks(int'(v.hold), v.expOpt, v.expCause);
    end else begin
      repeat (30) @(negedge clk);
      check(sawReset == 0 && sysRstN, "R8 short pulse ignored", sawReset, 0);
      check(optByte == v.expOpt, "R8 option unchanged", optByte, v.expOpt);
      check(rstCause == v.expCause, "R8 cause unchanged", rstCause, v.expCause);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    powerOn();
    flowChecks(0, 8'h5A, 3'b001);

    for (int i = 0; i < 7; i++) runVec(VECS[i]);

    // A second power-on clears the sticky cause (R10).
    optRdData = 8'h96; flashDly = 6;
    powerOn();
    flowChecks(0, 8'h96, 3'b001);

    // R9: a request arriving mid-flow is ignored.
    begin
      int n = 0;
      clearMon();
      optRdData = 8'h42; flashDly = 5; holdLen = 20;
      @(negedge clk);
      pulseLow = 1'b1;
      repeat (10) @(negedge clk);
      pulseLow = 1'b0;
      holdCnt = 0; holdLow = 1'b1;
      repeat (15) @(negedge clk);
      intRstReq = 1'b1;
      @(negedge clk);
      intRstReq = 1'b0;
      waitRun("R9 flow completes");
      flowChecks(20, 8'h42, 3'b011);
      sawReset = 0;
      while (n < 40) begin @(negedge clk); n++; end
      check(sawReset == 0 && sysRstN, "R9 no second flow", sawReset, 0);
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule